// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked host to an external asynchronous static RAM. The RAM has 19 address bits, 8 data bits and three active-low strobes: chip select, write strobe and output enable. The host raises a request together with a read/write flag, an address and, for a write, a byte. The controller then runs one memory access and returns a one-cycle completion pulse. A read also returns the fetched byte, which stays on its own output.

Each strobe pulse is a whole number of clock cycles. The number is the ceiling of a nanosecond minimum divided by the clock period, and both the period and every minimum are parameters. The controller drives its data bus only while the memory's outputs are disabled, so the memory and the controller never drive the bus together. The byte bus is split into an output, an input and a drive enable; the tristate pad sits outside this block.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and just after release, chip select, write strobe and output enable are high, the data drive enable is low, busy and done are low, and read data is 0.
- R2: A write holds chip select and write strobe low together for N_WACT = max(ceil(60/T), ceil(80/T), ceil(40/T)) cycles, where T is the clock period in ns (4 at 20 ns). During that time output enable is high, the address is the requested one, and the requested byte is driven on the data bus.
- R3: A read holds chip select and output enable low, with write strobe high, for N_RD = max(ceil((100+5)/T), ceil(100/T)) cycles (6 at 20 ns). The read data output then holds the byte that was on the bus during the last cycle of that window.
- R4: The data drive enable is never high while output enable is low. It stays high for N_WREC = max(1, ceil(5/T), N_CYC-N_WACT) cycles after the write strobe rises, where N_CYC = ceil(100/T).
- R5: Falling edges of chip select are at least ceil(100/T) cycles apart, and the write strobe stays high at least 5 ns between two write pulses.
- R6: Busy rises in the cycle after a request is accepted and stays high through a one-cycle done pulse. Done comes N_WACT+N_WREC cycles after acceptance for a write and N_RD cycles after acceptance for a read.
- R7: A request raised while busy is high is ignored. The address bus does not change, no extra done pulse appears, and memory is not written.
- R8: When no access is in progress, chip select is high (standby) and the data drive enable is low.
- R9: The read data output changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Byte returned by the last read |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 19 | Memory address bus |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Byte driven toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte seen on the memory data bus |

## Verification
The bench uses a timed memory model. The model returns the inverted byte until 100 ns after the latest change of chip select, output enable or address, so a capture taken too early shows up as wrong read data. It also reports write pulses, data setup and cycle spacing that are too short, and any cycle where both sides drive the bus. Directed cases cover unwritten locations, the lowest and highest addresses, all-zero and all-one bytes, a second request raised in the middle of a write, and a write that follows a read, which tells a held read result apart from a corrupted one. Random mixes of reads and writes on a small set of addresses at both ends of the address range then check read-after-write, write-after-write and back-to-back spacing.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WACT = 3'd1,
    ST_WREC = 3'd2,
    ST_RACT = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/100ps
module sram_ctrl_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/100ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW     = 3,
  parameter int unsigned N_WACT = 4,
  parameter int unsigned N_WREC = 1,
  parameter int unsigned N_RD   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic          dq_oe_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_state_e state_q, state_d;
  logic ce_n_q, we_n_q, oe_n_q, dq_oe_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        tmr_load_o = 1'b1;
        if (we_i) begin
          tmr_val_o = CW'(N_WACT - 1);
          state_d   = ST_WACT;
        end else begin
          tmr_val_o = CW'(N_RD - 1);
          state_d   = ST_RACT;
        end
      end
      ST_WACT: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(N_WREC - 1);
        state_d    = ST_WREC;
      end
      ST_WREC: if (tmr_zero_i) state_d = ST_DONE;
      ST_RACT: if (tmr_zero_i) begin
        capture_o = 1'b1;
        state_d   = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state: glitch-free, no added latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= !(state_d == ST_WACT || state_d == ST_RACT);
      we_n_q  <= !(state_d == ST_WACT);
      oe_n_q  <= !(state_d == ST_RACT);
      dq_oe_q <= (state_d == ST_WACT || state_d == ST_WREC);
    end
  end

  assign ce_n_o  = ce_n_q;
  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign dq_oe_o = dq_oe_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/100ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter int unsigned DW          = 8,
  parameter int unsigned CLK_NS      = 20,
  parameter int unsigned T_CYC_NS    = 100,
  parameter int unsigned T_ACC_NS    = 100,
  parameter int unsigned T_CAP_SU_NS = 5,
  parameter int unsigned T_WP_NS     = 60,
  parameter int unsigned T_CEW_NS    = 80,
  parameter int unsigned T_DS_NS     = 40,
  parameter int unsigned T_WHWL_NS   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned N_CYC  = ns2cyc(T_CYC_NS, CLK_NS);
  localparam int unsigned N_WACT = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CEW_NS, CLK_NS)),
                                        umax(ns2cyc(T_DS_NS, CLK_NS), 1));
  localparam int unsigned N_WREC = umax(umax(ns2cyc(T_WHWL_NS, CLK_NS), 1),
                                        (N_CYC > N_WACT) ? N_CYC - N_WACT : 1);
  localparam int unsigned N_RD   = umax(ns2cyc(T_ACC_NS + T_CAP_SU_NS, CLK_NS), N_CYC);
  localparam int unsigned CW     = $clog2(umax(umax(N_WACT, N_WREC), N_RD) + 1);

  logic          tmr_load, tmr_zero, accept, capture;
  logic [CW-1:0] tmr_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sram_ctrl_seq #(
    .CW(CW), .N_WACT(N_WACT), .N_WREC(N_WREC), .N_RD(N_RD)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_n_o     (mem_ce_no),
    .we_n_o     (mem_we_no),
    .oe_n_o     (mem_oe_no),
    .dq_oe_o    (mem_dq_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/100ps
module sram_async_ctrl_chk #(
  parameter int unsigned AW     = 19,
  parameter int unsigned N_WACT = 4,
  parameter int unsigned N_RD   = 6,
  parameter int unsigned N_CYC  = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_ce_no,
  input logic          mem_we_no,
  input logic          mem_oe_no,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o
);
  logic [15:0] we_run_q, oe_run_q, gap_q;
  logic        ce_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q <= '0;
      oe_run_q <= '0;
      gap_q    <= 16'(N_CYC);
      ce_d_q   <= 1'b1;
    end else begin
      we_run_q <= mem_we_no ? '0 : we_run_q + 1'b1;
      oe_run_q <= mem_oe_no ? '0 : oe_run_q + 1'b1;
      ce_d_q   <= mem_ce_no;
      if (ce_d_q && !mem_ce_no)  gap_q <= 16'd1;
      else if (gap_q != 16'hffff) gap_q <= gap_q + 1'b1;
    end
  end

  AST_WR_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && !mem_ce_no));                      // R2
  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_run_q == 16'(N_WACT)));                // R2
  AST_RD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> (oe_run_q == 16'(N_RD)));                  // R3
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);                                     // R4
  AST_CE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (gap_q >= 16'(N_CYC)));                    // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                            // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);                                // R6
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mem_addr_o));                                // R7
  AST_IDLE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_ce_no && !mem_dq_oe_o));                       // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .AW(AW), .N_WACT(N_WACT), .N_RD(N_RD), .N_CYC(N_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/100ps
module sram_async_ctrl_bench;
  localparam int CLK_NS = 20;

  function automatic int cdiv(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_CYC  = cdiv(100);
  localparam int E_WACT = imax(imax(cdiv(60), cdiv(80)), cdiv(40));
  localparam int E_WREC = imax(imax(1, cdiv(5)), E_CYC - E_WACT);
  localparam int E_RD   = imax(cdiv(105), E_CYC);

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        req = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, mem_dq_o, mem_dq_i;
  logic        busy, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [18:0] mem_addr;

  sram_async_ctrl u_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n),
    .mem_oe_no(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- timed memory model ----------------
  logic [7:0] mdl_mem [int];
  logic [7:0] ref_mem [int];
  function automatic logic [7:0] dflt(logic [18:0] a);
    return a[7:0] ^ a[18:11] ^ 8'h3c;
  endfunction
  function automatic logic [7:0] mdl_rd(logic [18:0] a);
    return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : dflt(a);
  endfunction
  function automatic logic [7:0] ref_rd(logic [18:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
  endfunction

  realtime t_ce_f = -1000.0, t_we_f = -1000.0, t_we_r = -1000.0, t_dq = 0.0, t_acc = 0.0;
  bit      have_ce = 1'b0;
  logic       mdrv = 1'b0;
  logic [7:0] mdata = '0;
  wire  [7:0] bus_w = mem_dq_oe ? mem_dq_o : 8'h00;
  assign mem_dq_i = mdrv ? mdata : 8'h00;

  always @(mem_dq_o or mem_dq_oe) t_dq = $realtime;
  always @(negedge mem_ce_n or negedge mem_oe_n or mem_addr) t_acc = $realtime;

  always @(negedge mem_ce_n) if (rst_n) begin
    if (have_ce) chk(($realtime - t_ce_f) >= 100.0, "R5 cycle time",
                     int'($realtime - t_ce_f), 100);
    have_ce = 1'b1;
    t_ce_f  = $realtime;
  end
  always @(negedge mem_we_n) if (rst_n) begin
    chk(($realtime - t_we_r) >= 5.0, "R5 write strobe high gap", int'($realtime - t_we_r), 5);
    t_we_f = $realtime;
  end
  always @(posedge mem_we_n) if (rst_n) begin
    chk(($realtime - t_we_f) >= 60.0, "R2 write pulse", int'($realtime - t_we_f), 60);
    chk(($realtime - t_ce_f) >= 80.0, "R2 select to write end", int'($realtime - t_ce_f), 80);
    chk(($realtime - t_dq) >= 40.0, "R2 data setup", int'($realtime - t_dq), 40);
    mdl_mem[int'(mem_addr)] = bus_w;
    t_we_r = $realtime;
  end

  initial begin
    #0.5;
    forever begin
      mdrv  = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (mdrv && mem_dq_oe) chk(1'b0, "R4 bus contention", 1, 0);
      mdata = (($realtime - t_acc) >= 100.0) ? mdl_rd(mem_addr) : ~mdl_rd(mem_addr);
      #1;
    end
  end

  // ---------------- port monitor ----------------
  int          we_run = 0, oe_run = 0;
  logic [7:0]  cur_wd = '0;
  logic [18:0] cur_a = '0;
  logic        done_prev = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n) begin
      we_run++;
      chk(mem_dq_oe && mem_dq_o == cur_wd && mem_oe_n && mem_addr == cur_a,
          "R2 write window", {23'd0, mem_dq_oe, mem_dq_o}, {24'd1, cur_wd});
    end else if (we_run != 0) begin
      chk(we_run == E_WACT, "R2 write strobe width", we_run, E_WACT);
      chk(mem_dq_oe, "R4 drive held after strobe", {31'd0, mem_dq_oe}, 1);
      we_run = 0;
    end
    if (!mem_oe_n) begin
      oe_run++;
      chk(!mem_ce_n && mem_we_n && !mem_dq_oe && mem_addr == cur_a,
          "R3 R4 read window", {13'd0, mem_addr}, {13'd0, cur_a});
    end else if (oe_run != 0) begin
      chk(oe_run == E_RD, "R3 read window width", oe_run, E_RD);
      oe_run = 0;
    end
    if (done && done_prev) chk(1'b0, "R6 done wider than one cycle", 2, 1);
    done_prev = done;
  end

  // ---------------- stimulus ----------------
  // call at a negedge with the block idle; returns at a negedge with it idle
  task automatic op(bit w, logic [18:0] a, logic [7:0] d, bit poke);
    int lat;
    cur_a = a; cur_wd = d;
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; lat = 1;
    chk(busy, "R6 busy after accept", {31'd0, busy}, 1);
    if (poke) begin
      req = 1'b1; we = 1'b1; addr = a ^ 19'h1; wdata = ~d;
      @(negedge clk);
      req = 1'b0; lat++;
    end
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
      if (!done) chk(busy, "R6 busy until done", {31'd0, busy}, 1);
    end
    chk(lat == (w ? E_WACT + E_WREC + 1 : E_RD + 1), "R6 done latency", lat,
        w ? E_WACT + E_WREC + 1 : E_RD + 1);
    if (w) ref_mem[int'(a)] = d;
    else   chk(rdata == ref_rd(a), "R3 read data", {24'd0, rdata}, {24'd0, ref_rd(a)});
    @(negedge clk);
    chk(!busy && !done && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R8 idle standby",
        {27'd0, busy, done, mem_ce_n, mem_oe_n, mem_dq_oe}, 32'h6);
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] held;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done && rdata == 8'h00,
        "R1 reset state", {rdata, 19'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, done},
        32'h38);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && !busy && !mem_dq_oe, "R1 after release", {29'd0, mem_ce_n, busy, mem_dq_oe}, 4);

    op(1'b0, 19'h00000, 8'h00, 1'b0);           // unwritten location
    op(1'b1, 19'h00000, 8'ha5, 1'b0);
    op(1'b0, 19'h00000, 8'h00, 1'b0);
    op(1'b1, 19'h7ffff, 8'h00, 1'b0);           // top address, all zeros
    op(1'b0, 19'h7ffff, 8'h00, 1'b0);
    op(1'b1, 19'h7ffff, 8'hff, 1'b0);
    op(1'b0, 19'h7ffff, 8'h00, 1'b0);

    // R7: second request while busy
    op(1'b1, 19'h00123, 8'h5a, 1'b1);
    op(1'b0, 19'h00122, 8'h00, 1'b0);
    chk(rdata == dflt(19'h00122), "R7 ignored request did not write",
        {24'd0, rdata}, {24'd0, dflt(19'h00122)});
    op(1'b0, 19'h00123, 8'h00, 1'b0);

    // R9: a write leaves the read result alone
    held = rdata;
    op(1'b1, 19'h00040, 8'hc3, 1'b0);
    chk(rdata == held, "R9 read data held over write", {24'd0, rdata}, {24'd0, held});
    op(1'b0, 19'h00040, 8'h00, 1'b0);
    chk(rdata == 8'hc3, "R9 read data updated by read", {24'd0, rdata}, 32'hc3);

    for (int i = 0; i < 60; i++) begin
      logic [18:0] a;
      a = (($urandom % 2) != 0 ? 19'h7fff0 : 19'h00000) | 19'($urandom % 16);
      op(1'(($urandom % 2) != 0), a, 8'($urandom), 1'(($urandom % 8) == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    chk(1'b0, "watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule